// File: doc/BRIEF.md
# Stretchable Quarter-Phase Cycle Sequencer

This block divides processor machine cycles into quarter phases. Each quarter lasts one period of the fast input clock. The block drives a one-hot strobe for the quarter that is active.

A plain cycle has four quarters. The memory-control logic can raise a stretch request when the cycle is a timing-critical local DRAM or VRAM access. The sequencer samples that request once, on the clock edge that ends the third quarter. If the request is high, the final quarter is split into two sub-quarters, so the cycle lasts five clocks. The earlier quarters keep their length, and cycles that do not request a stretch run at full speed.

The block also gives a start pulse in the first quarter and an end pulse in the last quarter, plus a flag that marks the split fourth quarter. There is no data stream, so there is no valid/ready handshake. The stretch request and all outputs are plain level signals that are valid every clock. The block never stalls and never applies back-pressure.

Top module: `qps_sequencer`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the next clock shows the first quarter: `phase_o[0]` high, `cyc_start_o` high, and `stretched_o` and `cyc_end_o` low.
- R2: Exactly one bit of `phase_o` is high in every clock. The bit meanings are: bit 0 = Q1, bit 1 = Q2, bit 2 = Q3, bit 3 = unsplit Q4, bit 4 = Q4a, bit 5 = Q4b.
- R3: If `stretch_req` is low at the edge that ends Q3, the cycle runs Q1, Q2, Q3, Q4 (bits 0, 1, 2, 3) and is followed by Q1.
- R4: If `stretch_req` is high at the edge that ends Q3, the cycle runs Q1, Q2, Q3, Q4a, Q4b (bits 0, 1, 2, 4, 5) and is followed by Q1.
- R5: `stretch_req` is looked at only on the edge that ends Q3. Its value during Q1, Q2, Q4, Q4a and Q4b has no effect on the phase sequence.
- R6: `cyc_end_o` is high exactly in Q4 and Q4b, and the clock after it always shows Q1.
- R7: `cyc_start_o` is high exactly in Q1.
- R8: `stretched_o` is high exactly in Q4a and Q4b and low in every other quarter.
- R9: Any run of cycles works with no lost or repeated quarter: back-to-back stretched cycles, back-to-back plain cycles, and any mix of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; one quarter per period |
| rst | input | 1 | Synchronous reset, active high |
| stretch_req | input | 1 | Stretch request for the current cycle, sampled at the end of Q3 |
| phase_o | output | NQ+2 (6) | One-hot quarter strobes: Q1, Q2, Q3, Q4, Q4a, Q4b |
| cyc_start_o | output | 1 | High during Q1 |
| cyc_end_o | output | 1 | High during the last quarter of the cycle (Q4 or Q4b) |
| stretched_o | output | 1 | High during Q4a and Q4b |

## Verification
All outputs are decoded from a single phase index. A corrupted index therefore shows at the ports in the same clock, as a wrong or missing strobe or as start, end and stretch flags that disagree with the strobe. A wrong decision at the end of Q3 shows one clock later: bit 3 appears where bit 4 was expected, or the other way round. A cycle that was lengthened or shortened by mistake is caught at its last quarter, because the following Q1 strobe and start pulse arrive a clock early or a clock late.

// File: rtl/qps_pkg.sv
package qps_pkg;
  // Number of quarters in a plain (unstretched) machine cycle
  localparam int QPS_DEF_QUARTERS = 4;

  // Number of phase strobes: base quarters plus the two halves of the split last quarter
  function automatic int qps_phase_count(input int nq);
    return nq + 2;
  endfunction
endpackage

// File: rtl/qps_state.sv
module qps_state #(
  parameter int NQ = qps_pkg::QPS_DEF_QUARTERS,
  parameter int IW = $clog2(qps_pkg::qps_phase_count(NQ))
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stretch_req,
  output logic [IW-1:0] idx_o
);
  // Index codes: 0..NQ-1 are the base quarters, NQ is Q4a, NQ+1 is Q4b
  localparam logic [IW-1:0] DECIDE_I = IW'(NQ - 2);
  localparam logic [IW-1:0] LAST_I   = IW'(NQ - 1);
  localparam logic [IW-1:0] SPLA_I   = IW'(NQ);
  localparam logic [IW-1:0] SPLB_I   = IW'(NQ + 1);

  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    if (idx_q == DECIDE_I)
      idx_d = stretch_req ? SPLA_I : LAST_I;
    else if (idx_q == SPLA_I)
      idx_d = SPLB_I;
    else if (idx_q == LAST_I || idx_q == SPLB_I)
      idx_d = '0;
    else
      idx_d = idx_q + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_q <= SPLB_I);  // R2
endmodule

// File: rtl/qps_decode.sv
module qps_decode #(
  parameter int NQ = qps_pkg::QPS_DEF_QUARTERS,
  parameter int PW = qps_pkg::qps_phase_count(NQ),
  parameter int IW = $clog2(PW)
) (
  input  logic [IW-1:0] idx_i,
  output logic [PW-1:0] phase_o,
  output logic          cyc_start_o,
  output logic          cyc_end_o,
  output logic          stretched_o
);
  for (genvar k = 0; k < PW; k++) begin : g_strobe
    assign phase_o[k] = (idx_i == IW'(k));
  end

  assign cyc_start_o = phase_o[0];
  assign cyc_end_o   = phase_o[NQ-1] | phase_o[NQ+1];
  assign stretched_o = phase_o[NQ] | phase_o[NQ+1];
endmodule

// File: rtl/qps_sequencer.sv
module qps_sequencer #(
  parameter int NQ = qps_pkg::QPS_DEF_QUARTERS,
  localparam int PW = qps_pkg::qps_phase_count(NQ),
  localparam int IW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stretch_req,
  output logic [PW-1:0] phase_o,
  output logic          cyc_start_o,
  output logic          cyc_end_o,
  output logic          stretched_o
);
  logic [IW-1:0] idx;

  qps_state #(.NQ(NQ), .IW(IW)) u_state (
    .clk         (clk),
    .rst         (rst),
    .stretch_req (stretch_req),
    .idx_o       (idx)
  );

  qps_decode #(.NQ(NQ), .PW(PW), .IW(IW)) u_decode (
    .idx_i       (idx),
    .phase_o     (phase_o),
    .cyc_start_o (cyc_start_o),
    .cyc_end_o   (cyc_end_o),
    .stretched_o (stretched_o)
  );

  AST_RESET_Q1: assert property (@(posedge clk)
    rst |=> (phase_o[0] && !stretched_o && !cyc_end_o));  // R1
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_o) == 1);  // R2
  AST_PLAIN_Q4: assert property (@(posedge clk) disable iff (rst)
    (phase_o[NQ-2] && !stretch_req) |=> phase_o[NQ-1]);  // R3
  AST_SPLIT_Q4A: assert property (@(posedge clk) disable iff (rst)
    (phase_o[NQ-2] && stretch_req) |=> phase_o[NQ]);  // R4
  AST_Q4A_HOLDS: assert property (@(posedge clk) disable iff (rst)
    phase_o[NQ] |=> phase_o[NQ+1]);  // R5
  AST_END_TO_START: assert property (@(posedge clk) disable iff (rst)
    cyc_end_o |=> cyc_start_o);  // R6
  AST_START_STEP: assert property (@(posedge clk) disable iff (rst)
    cyc_start_o |=> phase_o[1]);  // R7
  AST_FLAG_FALLS: assert property (@(posedge clk) disable iff (rst)
    $fell(stretched_o) |-> cyc_start_o);  // R8
endmodule

// File: tb/sim_qps_sequencer.sv
module sim_qps_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int PW = NQ + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stretch_req = 1'b0;
  logic [PW-1:0] phase_o;
  logic cyc_start_o, cyc_end_o, stretched_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string pat_tag = "R1";

  // reference model state: quarter number in cycle, and stretch decision
  int m_q = 0;
  bit m_str = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qps_sequencer #(.NQ(NQ)) u0 (
    .clk(clk), .rst(rst), .stretch_req(stretch_req),
    .phase_o(phase_o), .cyc_start_o(cyc_start_o),
    .cyc_end_o(cyc_end_o), .stretched_o(stretched_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_q = 0; m_str = 0;
    end else begin
      if (m_q == NQ - 2) m_str = stretch_req;
      m_q = m_q + 1;
      if ((m_q == NQ && !m_str) || m_q == NQ + 1) begin
        m_q = 0; m_str = 0;
      end
    end
  end

  function automatic int exp_bit();
    if (m_q < NQ - 1) return m_q;
    if (m_q == NQ - 1) return m_str ? NQ : NQ - 1;
    return NQ + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int eb;
    bit e_last, e_str;
    eb = exp_bit();
    e_last = (eb == NQ - 1) || (eb == NQ + 1);
    e_str = (eb >= NQ);
    chk("R2", $countones(phase_o), 1);
    chk(pat_tag, int'(phase_o), 1 << eb);
    chk("R7", int'(cyc_start_o), int'(eb == 0));
    chk("R6", int'(cyc_end_o), int'(e_last));
    chk("R8", int'(stretched_o), int'(e_str));
  endtask

  // mode: 0 low, 1 high, 2 random, 3 high except in Q3, 4 high only in Q3
  task automatic run(string tag, int mode, int ncyc);
    pat_tag = tag;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      compare_all();
      case (mode)
        0: stretch_req = 1'b0;
        1: stretch_req = 1'b1;
        2: stretch_req = 1'($urandom_range(0, 1));
        3: stretch_req = (m_q != NQ - 2);
        default: stretch_req = (m_q == NQ - 2);
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pat_tag = "R1";
    compare_all();                 // R1: first quarter after reset
    run("R3", 0, 40);              // plain cycles only
    run("R4", 1, 40);              // back-to-back stretched cycles
    run("R5", 3, 40);              // request held away from the Q3 edge: all plain
    run("R5", 4, 40);              // request only at the Q3 edge: all stretched
    run("R9", 2, 200);             // random mix
    @(negedge clk); rst = 1'b1; stretch_req = 1'b1;
    @(negedge clk); rst = 1'b0;
    pat_tag = "R1";
    compare_all();                 // R1: mid-run reset
    run("R9", 2, 100);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule